// File: doc/BRIEF.md
# Inter-thread FIFO mailbox cell

This block is one communication cell that threads use to pass 64-bit words to each other. It holds an eight-entry queue and a tag word with three flags: E (empty), F (full) and T (a spare flag that software owns). Every access picks one of four views. Two views are raw: one peeks at or patches the queue data, and one reads or rewrites the tag. The other two views are queue views that push and pop. One of these blocks and the other only tries.

The cell never stalls a processor itself. When a blocking access cannot go ahead, the cell returns a "block" response and records the thread ID in a blocked-thread mask. The next queue-view access that does not block sends the whole mask out as a one-cycle wake pulse and clears the mask. The processor side then decides how to park the thread and how to retry it.

The access port is a plain strobe and has no back-pressure. The cell accepts an access on every cycle in which `acc_valid` is high. Exactly one cycle later it returns `rsp_valid` with the read data, the block bit and the wake mask. The requester must take the response in that cycle, because the response is not held.

Top module: `mbox_cell`

## Requirements
- R1: After reset the cell holds count 0, read pointer 0, E=1, F=0 and T=0, with all data zero. A tag-view read then returns 0x0000_0000_3002_0001, and `rsp_block` and `wake_mask` are 0.
- R2: `acc_view` selects the view: 0 is raw, 1 is tag, 2 is the blocking queue view and 3 is the non-blocking queue view. A tag-view read returns these fields:
  - bits 31:28: log2 of the depth (3);
  - bits 27:18: the count;
  - bit 17: the FIFO-type flag, always 1;
  - bit 16: T;
  - bit 1: F;
  - bit 0: E;
  - all other bits: 0.
- R3: A tag-view write loads T, E and F from write-data bits 16, 0 and 1. If the new E is 1, the count becomes 0. The read pointer and the data entries do not change.
- R4: A queue-view read that does not block clears F. If the count is nonzero, it returns the entry at the read pointer, advances the pointer modulo 8 and decrements the count. If the count is zero afterwards, E is set.
- R5: A queue-view write clears E. If it does not block and the count is below 8, it stores the data at (read pointer + count) mod 8 and increments the count. When the count is 8 afterwards, F is set.
- R6: A blocking-view read while E is set returns `rsp_block`=1 and read data 0. It ORs bit `acc_tid` into the blocked mask and clears F. The count and the pointer do not change.
- R7: A blocking-view write while F is set returns `rsp_block`=1, ORs bit `acc_tid` into the blocked mask and clears E. It stores nothing.
- R8: A queue-view read with count 0 that does not block returns 0. A queue-view write with count 8 that does not block is dropped.
- R9: A queue-view access that does not block puts the blocked mask on `wake_mask` for the one response cycle and clears the mask. `wake_mask` is 0 in every other cycle.
- R10: A raw read returns the entry at the read pointer and does not pop it. A raw write with a nonzero count overwrites the entry at (read pointer + count − 1) mod 8. A raw write with count 0 is ignored.
- R11: Every access is accepted in the cycle that `acc_valid` is high. `rsp_valid` is high exactly one cycle later, and back-to-back accesses on consecutive cycles are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_view | input | 2 | View select (see R2) |
| acc_tid | input | 3 | Requesting thread ID |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_rdata | output | 64 | Read data |
| rsp_block | output | 1 | Access blocked, requester recorded |
| wake_mask | output | 8 | One-cycle pulse of the threads to wake |

## Verification
The bench goes after these corner cases, each with the failure it would expose:

- **Pointer wrap.** The read pointer wraps while the count is nonzero. A cell that computes the store index without the modulo would write outside the live window, and later pops would return stale words.
- **Raw write placement.** A raw write must patch the newest entry, not the oldest. A cell that uses the wrong offset would corrupt the head, and the next raw read would show it.
- **Flag clearing in a block.** A blocked access still clears the opposite flag. A cell that skips this would leave F set after a blocked read.
- **Tag write with E=1.** This must clear the count. A cell that misses it would report a stale count.
- **Wake mask.** The mask must be released only by an access that does not block. A cell that released it early would wake threads that are still waiting, or drop their bits.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {
    VW_RAW  = 2'd0,
    VW_TAG  = 2'd1,
    VW_WAIT = 2'd2,
    VW_POLL = 2'd3
  } view_e;

  localparam int unsigned TAG_CODE_LSB = 28;
  localparam int unsigned TAG_CNT_LSB  = 18;
  localparam int unsigned TAG_CNT_W    = 10;
  localparam int unsigned TAG_FIFO_BIT = 17;
  localparam int unsigned TAG_T_BIT    = 16;
  localparam int unsigned TAG_F_BIT    = 1;
  localparam int unsigned TAG_E_BIT    = 0;
endpackage

// File: rtl/mbc_store.sv
module mbc_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot[g] <= '0;
      else if (wr_en && wr_idx == AW'(g))    slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NTHR  = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned TW   = $clog2(NTHR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  view_e           acc_view,
  input  logic [TW-1:0]   acc_tid,
  input  logic            new_t,
  input  logic            new_e,
  input  logic            new_f,
  output logic [AW-1:0]   rptr,
  output logic [CW-1:0]   cnt,
  output logic            e_flag,
  output logic            f_flag,
  output logic            t_flag,
  output logic            deq_fire,
  output logic            st_wr_en,
  output logic [AW-1:0]   st_wr_idx,
  output logic            blk_q,
  output logic [NTHR-1:0] wake_q
);
  logic [NTHR-1:0] mask, mask_n;
  logic [AW-1:0]   rptr_n;
  logic [CW-1:0]   cnt_n;
  logic            e_n, f_n, t_n;
  logic            is_q, hold, ef_rd, ef_wr, rd_stall, wr_stall, stall, release_m;
  logic            enq_fire, raw_wr, tag_wr;
  logic [AW-1:0]   tail_idx;

  assign is_q      = (acc_view == VW_WAIT) || (acc_view == VW_POLL);
  assign hold      = (acc_view == VW_WAIT);
  assign ef_rd     = acc_en && !acc_wr && is_q;
  assign ef_wr     = acc_en &&  acc_wr && is_q;
  assign rd_stall  = ef_rd && hold && e_flag;
  assign wr_stall  = ef_wr && hold && f_flag;
  assign stall     = rd_stall || wr_stall;
  assign release_m = (ef_rd || ef_wr) && !stall;
  assign deq_fire  = ef_rd && !rd_stall && (cnt != '0);
  assign enq_fire  = ef_wr && !wr_stall && (cnt < CW'(DEPTH));
  assign raw_wr    = acc_en && acc_wr && (acc_view == VW_RAW) && (cnt != '0);
  assign tag_wr    = acc_en && acc_wr && (acc_view == VW_TAG);
  assign tail_idx  = rptr + cnt[AW-1:0];
  assign st_wr_en  = enq_fire || raw_wr;
  assign st_wr_idx = enq_fire ? tail_idx : tail_idx - AW'(1);

  always_comb begin
    rptr_n = rptr;
    cnt_n  = cnt;
    e_n    = e_flag;
    f_n    = f_flag;
    t_n    = t_flag;
    mask_n = mask;
    if (tag_wr) begin
      t_n = new_t;
      e_n = new_e;
      f_n = new_f;
      if (new_e) cnt_n = '0;
    end
    if (ef_rd) begin
      f_n = 1'b0;
      if (rd_stall) begin
        mask_n = mask | (NTHR'(1) << acc_tid);
      end else begin
        mask_n = '0;
        if (deq_fire) begin
          rptr_n = rptr + AW'(1);
          cnt_n  = cnt - CW'(1);
        end
        if (cnt_n == '0) e_n = 1'b1;
      end
    end
    if (ef_wr) begin
      e_n = 1'b0;
      if (wr_stall) begin
        mask_n = mask | (NTHR'(1) << acc_tid);
      end else begin
        mask_n = '0;
        if (enq_fire) cnt_n = cnt + CW'(1);
        if (cnt_n == CW'(DEPTH)) f_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      cnt    <= '0;
      e_flag <= 1'b1;
      f_flag <= 1'b0;
      t_flag <= 1'b0;
      mask   <= '0;
      blk_q  <= 1'b0;
      wake_q <= '0;
    end else begin
      rptr   <= rptr_n;
      cnt    <= cnt_n;
      e_flag <= e_n;
      f_flag <= f_n;
      t_flag <= t_n;
      mask   <= mask_n;
      blk_q  <= stall;
      wake_q <= release_m ? mask : '0;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R4
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_view == VW_POLL && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R6
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_view == VW_WAIT && e_flag) |=> (blk_q && $stable(cnt) && $stable(rptr)));

  // R9
  wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_view == VW_POLL) |=> (mask == '0 && wake_q == $past(mask)));

  // R3
  tag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_wr && new_e) |=> (cnt == '0 && e_flag));
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell
  import mbc_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NTHR  = 8,
  parameter int unsigned DW    = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned TW   = $clog2(NTHR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_view,
  input  logic [TW-1:0]   acc_tid,
  input  logic [DW-1:0]   acc_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_block,
  output logic [NTHR-1:0] wake_mask
);
  view_e          vw;
  logic [AW-1:0]  rptr, st_wr_idx;
  logic [CW-1:0]  cnt;
  logic           e_flag, f_flag, t_flag, deq_fire, st_wr_en;
  logic [DW-1:0]  head, tag_word, rdata_n;

  assign vw = view_e'(acc_view);

  mbc_ctrl #(.DEPTH(DEPTH), .NTHR(NTHR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_valid), .acc_wr(acc_write),
    .acc_view(vw), .acc_tid(acc_tid),
    .new_t(acc_wdata[TAG_T_BIT]), .new_e(acc_wdata[TAG_E_BIT]), .new_f(acc_wdata[TAG_F_BIT]),
    .rptr(rptr), .cnt(cnt), .e_flag(e_flag), .f_flag(f_flag), .t_flag(t_flag),
    .deq_fire(deq_fire), .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx),
    .blk_q(rsp_block), .wake_q(wake_mask)
  );

  mbc_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr_en), .wr_idx(st_wr_idx),
    .wr_data(acc_wdata), .rd_idx(rptr), .rd_data(head)
  );

  always_comb begin
    tag_word = '0;
    tag_word[TAG_CODE_LSB +: 4]        = 4'(AW);
    tag_word[TAG_CNT_LSB +: TAG_CNT_W] = TAG_CNT_W'(cnt);
    tag_word[TAG_FIFO_BIT]             = 1'b1;
    tag_word[TAG_T_BIT]                = t_flag;
    tag_word[TAG_F_BIT]                = f_flag;
    tag_word[TAG_E_BIT]                = e_flag;
  end

  always_comb begin
    rdata_n = '0;
    if (!acc_write) begin
      unique case (vw)
        VW_RAW:  rdata_n = head;
        VW_TAG:  rdata_n = tag_word;
        default: rdata_n = deq_fire ? head : '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_rdata <= acc_valid ? rdata_n : '0;
    end
  end

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  // R9
  wake_only_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mask != '0) |-> rsp_valid && !rsp_block);
endmodule

// File: tb/mbox_cell_test.sv
`timescale 1ns/1ps
module mbox_cell_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_view = 2'd0;
  logic [2:0]  acc_tid = 3'd0;
  logic [63:0] acc_wdata = '0;
  logic        rsp_valid, rsp_block;
  logic [63:0] rsp_rdata;
  logic [7:0]  wake_mask;

  int checks = 0, fails = 0;

  logic [63:0] mq [8];
  int          mrp, mcnt;
  bit          mE, mF, mT;
  logic [7:0]  mmask;

  always #2 clk = ~clk;

  mbox_cell uut (.*);

  task automatic chk(string tg, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tg, act, exp, $time);
    end
  endtask

  task automatic model(input bit wr, input logic [1:0] vw, input logic [2:0] tid,
                       input logic [63:0] d, output logic [63:0] er, output bit eb,
                       output logic [7:0] ew, output string tg);
    bit blocking;
    er = '0; eb = 0; ew = '0; tg = "R10";
    case (vw)
      2'd0: begin
        if (!wr) er = mq[mrp];
        else if (mcnt != 0) mq[(mrp + mcnt - 1) % 8] = d;
        tg = "R10";
      end
      2'd1: begin
        if (!wr) begin
          er = (64'd3 << 28) | (64'(mcnt) << 18) | (64'd1 << 17) | (64'(mT) << 16)
             | (64'(mF) << 1) | 64'(mE);
          tg = "R2";
        end else begin
          mT = d[16]; mE = d[0]; mF = d[1];
          if (mE) mcnt = 0;
          tg = "R3";
        end
      end
      default: begin
        blocking = (vw == 2'd2);
        if (!wr) begin
          mF = 0;
          if (blocking && mE) begin
            mmask |= 8'd1 << tid; eb = 1; tg = "R6";
          end else begin
            ew = mmask; mmask = '0;
            if (mcnt > 0) begin
              er = mq[mrp]; mrp = (mrp + 1) % 8; mcnt--; tg = "R4";
            end else tg = "R8";
            if (mcnt == 0) mE = 1;
          end
        end else begin
          mE = 0;
          if (blocking && mF) begin
            mmask |= 8'd1 << tid; eb = 1; tg = "R7";
          end else begin
            ew = mmask; mmask = '0;
            if (mcnt < 8) begin
              mq[(mrp + mcnt) % 8] = d; mcnt++; tg = "R5";
            end else tg = "R8";
            if (mcnt == 8) mF = 1;
          end
        end
      end
    endcase
  endtask

  // Called at a falling edge; applies one access and checks its response.
  task automatic access(bit wr, logic [1:0] vw, logic [2:0] tid, logic [63:0] d);
    logic [63:0] er; bit eb; logic [7:0] ew; string tg;
    model(wr, vw, tid, d, er, eb, ew, tg);
    acc_valid = 1; acc_write = wr; acc_view = vw; acc_tid = tid; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0;
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    chk({tg, " rdata"}, rsp_rdata, er);
    chk({tg, " block"}, 64'(rsp_block), 64'(eb));
    chk("R9 wake", 64'(wake_mask), 64'(ew));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) mq[i] = '0;
    mrp = 0; mcnt = 0; mE = 1; mF = 0; mT = 0; mmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs and reset tag value
    chk("R1 idle wake", 64'(wake_mask), 64'd0);
    chk("R1 idle block", 64'(rsp_block), 64'd0);
    access(0, 2'd1, 0, '0);
    chk("R1 reset tag", rsp_rdata, 64'h3002_0001);
    // R10: raw write with count zero ignored
    access(1, 2'd0, 0, 64'hDEAD);
    access(0, 2'd0, 0, '0);
    // R5/R8: fill to full, then drop one more
    for (int i = 0; i < 8; i++) access(1, 2'd3, 3'(i), 64'h100 + 64'(i));
    access(0, 2'd1, 0, '0);
    access(1, 2'd3, 0, 64'hBAD);
    // R7: blocked writes from threads 5 and 2
    access(1, 2'd2, 3'd5, 64'hBAD1);
    access(1, 2'd2, 3'd2, 64'hBAD2);
    access(0, 2'd1, 0, '0);
    // R10: raw peek twice, overwrite newest
    access(0, 2'd0, 0, '0);
    access(0, 2'd0, 0, '0);
    access(1, 2'd0, 0, 64'hABCD);
    // R9: non-blocking pop releases mask 0x24
    access(0, 2'd3, 0, '0);
    access(0, 2'd1, 0, '0);
    for (int i = 0; i < 8; i++) access(0, 2'd3, 0, '0);
    // R6: blocking read on empty; R3: tag write with E
    access(0, 2'd2, 3'd7, '0);
    access(1, 2'd1, 0, 64'h0001_0000);
    access(1, 2'd2, 3'd1, 64'h77);
    access(1, 2'd1, 0, 64'h0001_0003);
    access(0, 2'd1, 0, '0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(99));
      logic [1:0] vw;
      logic [63:0] d = {$urandom, $urandom};
      if (r < 8) vw = 2'd0;
      else if (r < 13) vw = 2'd1;
      else if (r < 50) vw = 2'd2;
      else vw = 2'd3;
      if (vw == 2'd1 && $urandom_range(3) != 0) d[0] = 1'b0;
      access(bit'($urandom_range(1)), vw, 3'($urandom_range(7)), d);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule